// File: doc/BRIEF.md
# Flash Memory Controller Model

This block stands in for an on-chip flash controller. It holds a word-addressed flash array organised as pages, plus a small user configuration area. A 32-bit register port carries a status register, a control register with separate program and erase enables, and the erase command registers. A separate 32-bit flash data port handles reads and program writes, and a third word port reads and writes the configuration area.

Programming behaves like real flash. A program write can only clear bits, because the stored word becomes the AND of the old and the new data. Erasing sets bits back to one. There are three erase commands: one for a single page, one for the whole array together with the configuration area, and one for the configuration area alone. The configuration-area erase is not gated by the erase enable. Every erase runs through the array one word per cycle. While an erase is running, a busy output holds off data writes and further erase commands, but the status register still reports ready.

Top module: `nvm_ctrl`

## Requirements
- R1: Reset sets the control register to 0, fills the configuration area with 0xFFFFFFFF and clears busy. The flash array keeps its contents across reset.
- R2: The control register sits at offset 0x04. Bit 0 is the program enable and bit 1 is the erase enable. Any other written bits are dropped and read back as 0.
- R3: The status register at offset 0x00 always reads 0x00000001, including while busy is high.
- R4: A flash write while the program enable is clear leaves the array unchanged. It raises fl_err in the cycle after the write.
- R5: A flash write while the program enable is set stores the old word AND the new data.
- R6: A write of a byte address to offset 0x08 or 0x0C while the erase enable is set first rounds the address down to a multiple of PAGE_WORDS*4. If that page lies wholly inside the flash, only that page becomes all ones. Otherwise nothing changes. With the erase enable clear, the write is ignored and reg_err is raised.
- R7: Writing the key value 0x00000001 to offset 0x10 while the erase enable is set fills the flash array and the configuration area with ones. Any other value is ignored with no error. The key written while the erase enable is clear is ignored and raises reg_err.
- R8: Writing the key value 0x00000001 to offset 0x14 fills the configuration area with ones, whatever the state of the erase enable.
- R9: A read of any offset other than 0x00 or 0x04 returns 0 and raises reg_err. A write to any offset other than 0x04, 0x08, 0x0C, 0x10 or 0x14 changes nothing and raises reg_err.
- R10: busy rises in the cycle after an accepted erase command. It stays high for one cycle per erased word: PAGE_WORDS cycles for a page erase, FLASH_WORDS+CFG_WORDS cycles for a full erase, and CFG_WORDS cycles for a configuration-area erase.
- R11: While busy is high, flash writes are ignored and raise fl_err, configuration-area writes are ignored, and erase commands are ignored and raise reg_err.
- R12: A configuration-area write stores the data word unchanged, with no AND, and it reads back on cf_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for error flagging) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| reg_err | output | 1 | One-cycle pulse after a rejected register access |
| fl_wr | input | 1 | Flash program write strobe |
| fl_addr | input | $clog2(FLASH_WORDS) | Flash word index |
| fl_wdata | input | 32 | Flash program data |
| fl_rdata | output | 32 | Flash read data, combinational from fl_addr |
| fl_err | output | 1 | One-cycle pulse after a rejected flash write |
| busy | output | 1 | Erase sequence in progress |
| cf_wr | input | 1 | Configuration-area write strobe |
| cf_addr | input | $clog2(CFG_WORDS) | Configuration-area word index |
| cf_wdata | input | 32 | Configuration-area write data |
| cf_rdata | output | 32 | Configuration-area read data, combinational |

## Verification
Read data is combinational, so the bench checks reads in the same cycle it drives the address. It samples them before the next rising edge. The control register, the stored words and both error pulses are each one register away from their strobe, so they are checked at the falling edge that follows the capturing edge. Erase results are checked only after busy has fallen. For the busy window, the bench counts the falling edges with busy high, starting just after the command is captured, and compares that count with the word count of the erase. The bench places writes made during an erase so that they are captured inside that window.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_STATUS   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_CONTROL  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_PGWIPE_A = 8'h08;
    localparam logic [REG_AW-1:0] OFS_PGWIPE_B = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_WIPE_ALL = 8'h10;
    localparam logic [REG_AW-1:0] OFS_WIPE_CFG = 8'h14;

    localparam logic [31:0] WIPE_KEY = 32'h0000_0001;

    typedef struct packed {
        logic een;
        logic wen;
    } nvm_cfg_t;

    typedef enum logic [1:0] {
        ER_NONE,
        ER_PAGE,
        ER_ALL,
        ER_CFG
    } erase_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FLASH,
        PH_CFG
    } erase_phase_e;
endpackage

// File: rtl/nvm_regs.sv
module nvm_regs import nvm_pkg::*; #(
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned FLASH_PAGES = 8,
    localparam int unsigned PAGE_BYTES  = PAGE_WORDS * 4,
    localparam int unsigned FLASH_BYTES = PAGE_BYTES * FLASH_PAGES,
    localparam int unsigned PB_W        = $clog2(PAGE_BYTES),
    localparam int unsigned PG_W        = (FLASH_PAGES > 1) ? $clog2(FLASH_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    output nvm_cfg_t          cfg,
    output erase_kind_e       er_kind,
    output logic [PG_W-1:0]   er_page
);
    typedef struct packed {
        nvm_cfg_t cfg;
        logic     err;
    } regs_st_t;

    regs_st_t    st_d, st_q;
    logic [31:0] aligned;
    logic        in_range;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        er_kind   = ER_NONE;
        aligned   = reg_wdata & ~(32'(PAGE_BYTES) - 32'd1);
        in_range  = aligned <= 32'(FLASH_BYTES - PAGE_BYTES);
        er_page   = aligned[PB_W +: PG_W];

        case (reg_addr)
            OFS_STATUS:  reg_rdata = 32'd1;
            OFS_CONTROL: reg_rdata = {30'd0, st_q.cfg};
            default:     reg_rdata = 32'd0;
        endcase

        if (reg_rd && reg_addr != OFS_STATUS && reg_addr != OFS_CONTROL) begin
            st_d.err = 1'b1;
        end

        if (reg_wr) begin
            case (reg_addr)
                OFS_CONTROL: st_d.cfg = nvm_cfg_t'(reg_wdata[1:0]);
                OFS_PGWIPE_A, OFS_PGWIPE_B: begin
                    if (!st_q.cfg.een || busy) st_d.err = 1'b1;
                    else if (in_range)         er_kind  = ER_PAGE;
                end
                OFS_WIPE_ALL: begin
                    if (reg_wdata == WIPE_KEY) begin
                        if (!st_q.cfg.een || busy) st_d.err = 1'b1;
                        else                       er_kind  = ER_ALL;
                    end
                end
                OFS_WIPE_CFG: begin
                    if (reg_wdata == WIPE_KEY) begin
                        if (busy) st_d.err = 1'b1;
                        else      er_kind  = ER_CFG;
                    end
                end
                default: st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign reg_err = st_q.err;

    // R2
    cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CONTROL) |=> (cfg == nvm_cfg_t'($past(reg_wdata[1:0]))));

    // R3
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_addr == OFS_STATUS) |-> (reg_rdata == 32'd1));
endmodule

// File: rtl/nvm_eraser.sv
module nvm_eraser import nvm_pkg::*; #(
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned FLASH_PAGES = 8,
    parameter int unsigned CFG_WORDS   = 4,
    localparam int unsigned FLASH_WORDS = PAGE_WORDS * FLASH_PAGES,
    localparam int unsigned MAX_WORDS   = (FLASH_WORDS > CFG_WORDS) ? FLASH_WORDS : CFG_WORDS,
    localparam int unsigned CNT_W       = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int unsigned FW_W        = (FLASH_WORDS > 1) ? $clog2(FLASH_WORDS) : 1,
    localparam int unsigned CW_W        = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1,
    localparam int unsigned PG_W        = (FLASH_PAGES > 1) ? $clog2(FLASH_PAGES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  erase_kind_e     er_kind,
    input  logic [PG_W-1:0] er_page,
    output logic            busy,
    output logic            fl_wipe,
    output logic [FW_W-1:0] fl_wipe_idx,
    output logic            cf_wipe,
    output logic [CW_W-1:0] cf_wipe_idx
);
    typedef struct packed {
        erase_phase_e     phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic             then_cfg;
    } er_st_t;

    er_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        fl_wipe     = 1'b0;
        cf_wipe     = 1'b0;
        fl_wipe_idx = st_q.cnt[FW_W-1:0];
        cf_wipe_idx = st_q.cnt[CW_W-1:0];

        case (st_q.phase)
            PH_IDLE: begin
                case (er_kind)
                    ER_PAGE: begin
                        st_d.phase    = PH_FLASH;
                        st_d.cnt      = CNT_W'(er_page * PAGE_WORDS);
                        st_d.last     = CNT_W'(er_page * PAGE_WORDS + PAGE_WORDS - 1);
                        st_d.then_cfg = 1'b0;
                    end
                    ER_ALL: begin
                        st_d.phase    = PH_FLASH;
                        st_d.cnt      = '0;
                        st_d.last     = CNT_W'(FLASH_WORDS - 1);
                        st_d.then_cfg = 1'b1;
                    end
                    ER_CFG: begin
                        st_d.phase    = PH_CFG;
                        st_d.cnt      = '0;
                        st_d.last     = CNT_W'(CFG_WORDS - 1);
                        st_d.then_cfg = 1'b0;
                    end
                    default: ;
                endcase
            end
            PH_FLASH: begin
                fl_wipe = 1'b1;
                if (st_q.cnt == st_q.last) begin
                    if (st_q.then_cfg) begin
                        st_d.phase    = PH_CFG;
                        st_d.cnt      = '0;
                        st_d.last     = CNT_W'(CFG_WORDS - 1);
                        st_d.then_cfg = 1'b0;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_CFG: begin
                cf_wipe = 1'b1;
                if (st_q.cnt == st_q.last) st_d.phase = PH_IDLE;
                else                       st_d.cnt   = st_q.cnt + 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_IDLE);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt <= st_q.last));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && er_kind != ER_NONE) |=> busy);
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int unsigned WORDS       = 32,
    parameter bit          AND_PROGRAM = 1'b1,
    parameter bit          RESET_ONES  = 1'b0,
    localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [IW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic          wipe,
    input  logic [IW-1:0] wipe_idx,
    input  logic [IW-1:0] ridx,
    output logic [31:0]   rdata
);
    logic [31:0] mem_d [WORDS];
    logic [31:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wipe) begin
            mem_d[wipe_idx] = '1;
        end else if (wr) begin
            mem_d[widx] = AND_PROGRAM ? (mem_q[widx] & wdata) : wdata;
        end
    end

    generate
        if (RESET_ONES) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
                end else begin
                    mem_q <= mem_d;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                mem_q <= mem_d;
            end
        end
    endgenerate

    assign rdata = mem_q[ridx];

    generate
        if (AND_PROGRAM) begin : g_and_chk
            // R5
            prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && !wipe) |=> (mem_q[$past(widx)] == ($past(mem_q[widx]) & $past(wdata))));
        end else begin : g_plain_chk
            // R12
            plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && !wipe) |=> (mem_q[$past(widx)] == $past(wdata)));
        end
    endgenerate

    // R6
    wipe_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (mem_q[$past(wipe_idx)] == 32'hFFFF_FFFF));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl import nvm_pkg::*; #(
    parameter int unsigned PAGE_WORDS  = 4,
    parameter int unsigned FLASH_PAGES = 8,
    parameter int unsigned CFG_WORDS   = 4,
    localparam int unsigned FLASH_WORDS = PAGE_WORDS * FLASH_PAGES,
    localparam int unsigned FW_W        = (FLASH_WORDS > 1) ? $clog2(FLASH_WORDS) : 1,
    localparam int unsigned CW_W        = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic              fl_wr,
    input  logic [FW_W-1:0]   fl_addr,
    input  logic [31:0]       fl_wdata,
    output logic [31:0]       fl_rdata,
    output logic              fl_err,
    output logic              busy,
    input  logic              cf_wr,
    input  logic [CW_W-1:0]   cf_addr,
    input  logic [31:0]       cf_wdata,
    output logic [31:0]       cf_rdata
);
    localparam int unsigned PG_W = (FLASH_PAGES > 1) ? $clog2(FLASH_PAGES) : 1;

    nvm_cfg_t        cfg;
    erase_kind_e     er_kind;
    logic [PG_W-1:0] er_page;
    logic            fl_wipe, cf_wipe;
    logic [FW_W-1:0] fl_wipe_idx;
    logic [CW_W-1:0] cf_wipe_idx;
    logic            fl_accept, cf_accept;
    logic            fl_err_d, fl_err_q;

    nvm_regs #(.PAGE_WORDS(PAGE_WORDS), .FLASH_PAGES(FLASH_PAGES)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .cfg(cfg),
        .er_kind(er_kind), .er_page(er_page)
    );

    nvm_eraser #(.PAGE_WORDS(PAGE_WORDS), .FLASH_PAGES(FLASH_PAGES), .CFG_WORDS(CFG_WORDS)) i_eraser (
        .clk(clk), .rst_n(rst_n), .er_kind(er_kind), .er_page(er_page),
        .busy(busy), .fl_wipe(fl_wipe), .fl_wipe_idx(fl_wipe_idx),
        .cf_wipe(cf_wipe), .cf_wipe_idx(cf_wipe_idx)
    );

    assign fl_accept = fl_wr && cfg.wen && !busy;
    assign cf_accept = cf_wr && !busy;

    nvm_store #(.WORDS(FLASH_WORDS), .AND_PROGRAM(1'b1), .RESET_ONES(1'b0)) i_flash (
        .clk(clk), .rst_n(rst_n), .wr(fl_accept), .widx(fl_addr), .wdata(fl_wdata),
        .wipe(fl_wipe), .wipe_idx(fl_wipe_idx), .ridx(fl_addr), .rdata(fl_rdata)
    );

    nvm_store #(.WORDS(CFG_WORDS), .AND_PROGRAM(1'b0), .RESET_ONES(1'b1)) i_cfgarea (
        .clk(clk), .rst_n(rst_n), .wr(cf_accept), .widx(cf_addr), .wdata(cf_wdata),
        .wipe(cf_wipe), .wipe_idx(cf_wipe_idx), .ridx(cf_addr), .rdata(cf_rdata)
    );

    always_comb begin
        fl_err_d = fl_wr && (!cfg.wen || busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_err_q <= 1'b0;
        else        fl_err_q <= fl_err_d;
    end

    assign fl_err = fl_err_q;

    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && !cfg.wen) |=> fl_err);

    // R11
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && busy) |=> fl_err);
endmodule

// File: tb/test_nvm_ctrl.sv
module test_nvm_ctrl;
    localparam int unsigned PW = 4, NP = 8, CW = 4;
    localparam int unsigned FLASH_WORDS = PW * NP;

    localparam logic [2:0] OP_RW = 3'd0, OP_RR = 3'd1, OP_FW = 3'd2, OP_FR = 3'd3,
                           OP_CW = 3'd4, OP_CR = 3'd5, OP_WAIT = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    // flash addr = word index, cfg addr = word index, reg addr = byte offset
    localparam vec_t VEC [NV] = '{
        '{OP_RR, 8'h00, 32'h0, 32'h1,         1'b0, 4'd3},  // R3 status ready
        '{OP_RR, 8'h04, 32'h0, 32'h0,         1'b0, 4'd1},  // R1 control zero
        '{OP_RW, 8'h04, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd2},  // R2 masked write
        '{OP_RR, 8'h04, 32'h0, 32'h3,         1'b0, 4'd2},  // R2
        '{OP_RW, 8'h10, 32'h1, 32'h0,         1'b0, 4'd7},  // R7 erase all
        '{OP_WAIT, 8'h0, 32'h0, 32'h0,        1'b0, 4'd7},
        '{OP_FR, 8'h00, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd7},  // R7
        '{OP_FR, 8'h1F, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd7},  // R7
        '{OP_CR, 8'h03, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd7},  // R7
        '{OP_FW, 8'h04, 32'hF0F0_FF00, 32'h0, 1'b0, 4'd5},  // R5
        '{OP_FW, 8'h04, 32'h0FF0_F0FF, 32'h0, 1'b0, 4'd5},  // R5
        '{OP_FR, 8'h04, 32'h0, 32'h00F0_F000, 1'b0, 4'd5},  // R5 AND result
        '{OP_FW, 8'h08, 32'h1234_5678, 32'h0, 1'b0, 4'd5},  // R5
        '{OP_FW, 8'h01, 32'hA5A5_0000, 32'h0, 1'b0, 4'd5},  // R5
        '{OP_FR, 8'h01, 32'h0, 32'hA5A5_0000, 1'b0, 4'd5},  // R5
        '{OP_RW, 8'h04, 32'h2, 32'h0,         1'b0, 4'd2},  // R2 erase only
        '{OP_FW, 8'h08, 32'h0, 32'h0,         1'b1, 4'd4},  // R4 locked write
        '{OP_FR, 8'h08, 32'h0, 32'h1234_5678, 1'b0, 4'd4},  // R4 unchanged
        '{OP_RW, 8'h08, 32'h2B, 32'h0,        1'b0, 4'd6},  // R6 page at 0x20
        '{OP_WAIT, 8'h0, 32'h0, 32'h0,        1'b0, 4'd6},
        '{OP_FR, 8'h08, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd6},  // R6
        '{OP_FR, 8'h04, 32'h0, 32'h00F0_F000, 1'b0, 4'd6},  // R6 neighbour kept
        '{OP_RW, 8'h10, 32'h2, 32'h0,         1'b0, 4'd7},  // R7 wrong key
        '{OP_WAIT, 8'h0, 32'h0, 32'h0,        1'b0, 4'd7},
        '{OP_FR, 8'h04, 32'h0, 32'h00F0_F000, 1'b0, 4'd7},  // R7 ignored
        '{OP_RW, 8'h0C, 32'h80, 32'h0,        1'b0, 4'd6},  // R6 outside flash
        '{OP_WAIT, 8'h0, 32'h0, 32'h0,        1'b0, 4'd6},
        '{OP_FR, 8'h01, 32'h0, 32'hA5A5_0000, 1'b0, 4'd6},  // R6 page 0 kept
        '{OP_RW, 8'h04, 32'h0, 32'h0,         1'b0, 4'd2},  // R2 all off
        '{OP_RW, 8'h08, 32'h0, 32'h0,         1'b1, 4'd6},  // R6 erase disabled
        '{OP_FR, 8'h01, 32'h0, 32'hA5A5_0000, 1'b0, 4'd6},  // R6
        '{OP_RW, 8'h10, 32'h1, 32'h0,         1'b1, 4'd7},  // R7 disabled
        '{OP_FR, 8'h01, 32'h0, 32'hA5A5_0000, 1'b0, 4'd7},  // R7
        '{OP_CW, 8'h02, 32'h0000_BEEF, 32'h0, 1'b0, 4'd12}, // R12
        '{OP_CW, 8'h02, 32'h1111_0000, 32'h0, 1'b0, 4'd12}, // R12 no AND
        '{OP_CR, 8'h02, 32'h0, 32'h1111_0000, 1'b0, 4'd12}, // R12
        '{OP_RW, 8'h14, 32'h1, 32'h0,         1'b0, 4'd8},  // R8 enable-free
        '{OP_WAIT, 8'h0, 32'h0, 32'h0,        1'b0, 4'd8},
        '{OP_CR, 8'h02, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd8},  // R8
        '{OP_RR, 8'h18, 32'h0, 32'h0,         1'b1, 4'd9}   // R9 bad read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        fl_wr = 1'b0;
    logic [4:0]  fl_addr = '0;
    logic [31:0] fl_wdata = '0;
    logic [31:0] fl_rdata;
    logic        fl_err, busy;
    logic        cf_wr = 1'b0;
    logic [1:0]  cf_addr = '0;
    logic [31:0] cf_wdata = '0;
    logic [31:0] cf_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nvm_ctrl #(.PAGE_WORDS(PW), .FLASH_PAGES(NP), .CFG_WORDS(CW)) i_nvm_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_err(fl_err), .busy(busy), .cf_wr(cf_wr),
        .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic run(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.req);
        case (v.op)
            OP_RW: begin
                reg_addr = v.addr; reg_wdata = v.data; reg_wr = 1'b1;
                @(negedge clk); reg_wr = 1'b0;
                chk(rq, "reg_err", 32'(reg_err), 32'(v.eerr));
            end
            OP_RR: begin
                reg_addr = v.addr; reg_rd = 1'b1; #1;
                chk(rq, "reg_rdata", reg_rdata, v.exp);
                @(negedge clk); reg_rd = 1'b0;
                chk(rq, "reg_err", 32'(reg_err), 32'(v.eerr));
            end
            OP_FW: begin
                fl_addr = v.addr[4:0]; fl_wdata = v.data; fl_wr = 1'b1;
                @(negedge clk); fl_wr = 1'b0;
                chk(rq, "fl_err", 32'(fl_err), 32'(v.eerr));
            end
            OP_FR: begin
                fl_addr = v.addr[4:0]; #1;
                chk(rq, "fl_rdata", fl_rdata, v.exp);
                @(negedge clk);
            end
            OP_CW: begin
                cf_addr = v.addr[1:0]; cf_wdata = v.data; cf_wr = 1'b1;
                @(negedge clk); cf_wr = 1'b0;
            end
            OP_CR: begin
                cf_addr = v.addr[1:0]; #1;
                chk(rq, "cf_rdata", cf_rdata, v.exp);
                @(negedge clk);
            end
            default: begin
                while (busy) @(negedge clk);
            end
        endcase
    endtask

    function automatic vec_t mk(input logic [2:0] op, input logic [7:0] a, input logic [31:0] d,
                                input logic [31:0] e, input logic ee, input logic [3:0] r);
        return '{op, a, d, e, ee, r};
    endfunction

    task automatic busy_len(input logic [7:0] ofs, input logic [31:0] val, input int exp, input string rq);
        int n;
        run(mk(OP_RW, ofs, val, 32'h0, 1'b0, 4'd10));
        n = 0;
        reg_addr = 8'h00; #1;
        // R3 status stays ready during erase
        chk("R3", "status while busy", reg_rdata, 32'h1);
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(rq, "busy cycles", 32'(n), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 32'h0);
        run(mk(OP_CR, 8'h00, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1));  // R1

        for (int i = 0; i < NV; i++) run(VEC[i]);

        // R9 reads and writes of unmapped offsets
        run(mk(OP_RR, 8'h08, 32'h0, 32'h0, 1'b1, 4'd9));           // R9
        run(mk(OP_RW, 8'h18, 32'h3, 32'h0, 1'b1, 4'd9));           // R9
        run(mk(OP_RW, 8'h00, 32'h3, 32'h0, 1'b1, 4'd9));           // R9
        run(mk(OP_RR, 8'h04, 32'h0, 32'h0, 1'b0, 4'd9));           // R9 control untouched

        // R10 erase lengths
        run(mk(OP_RW, 8'h04, 32'h3, 32'h0, 1'b0, 4'd2));
        busy_len(8'h0C, 32'h70, PW, "R10 page");
        busy_len(8'h14, 32'h1, CW, "R10 cfg");
        run(mk(OP_FW, 8'h01, 32'hA5A5_0000, 32'h0, 1'b0, 4'd5));   // restore after next erase
        busy_len(8'h10, 32'h1, FLASH_WORDS + CW, "R10 all");

        // R11 writes and commands during an erase
        run(mk(OP_FW, 8'h01, 32'hA5A5_0000, 32'h0, 1'b0, 4'd5));
        run(mk(OP_CW, 8'h00, 32'h0, 32'h0, 1'b0, 4'd12));
        run(mk(OP_RW, 8'h08, 32'h70, 32'h0, 1'b0, 4'd11));         // page 7
        run(mk(OP_FW, 8'h01, 32'h0, 32'h0, 1'b1, 4'd11));          // R11 rejected
        run(mk(OP_CW, 8'h01, 32'h0, 32'h0, 1'b0, 4'd11));          // R11 ignored
        run(mk(OP_RW, 8'h14, 32'h1, 32'h0, 1'b1, 4'd11));          // R11 rejected
        run(mk(OP_WAIT, 8'h0, 32'h0, 32'h0, 1'b0, 4'd11));
        run(mk(OP_FR, 8'h01, 32'h0, 32'hA5A5_0000, 1'b0, 4'd11));  // R11
        run(mk(OP_CR, 8'h01, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd11));  // R11
        run(mk(OP_CR, 8'h00, 32'h0, 32'h0, 1'b0, 4'd11));          // R11 cfg erase dropped

        // R1 reset keeps flash, restores control and cfg area
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run(mk(OP_FR, 8'h01, 32'h0, 32'hA5A5_0000, 1'b0, 4'd1));   // R1
        run(mk(OP_CR, 8'h00, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1));   // R1
        run(mk(OP_RR, 8'h04, 32'h0, 32'h0, 1'b0, 4'd1));           // R1

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule